// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns one host request into the command and address cycles of a parallel NAND flash bus. A request holds an opcode, an optional column address and an optional page (row) address. It also holds configuration bits for large-page layout, a 16-bit data bus and a third row byte. The block drives chip enable, the command-latch and address-latch strobes, write enable, the data bus and its output enable.

Some requests need extra bus cycles, and the block adds them. In small-page mode a program setup is preceded by a read-pointer opcode. In large-page mode an addressed read gets a confirm opcode, and so does a random data-out.

When the last cycle ends, the block pulses `done` together with a code for the wait that the host must apply next. That wait may be nothing, the column-change delay, or a wait on ready/busy. The block does not perform the wait itself. It does not move page data.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. `nand_ce_n` is low exactly while bus cycles run. `done` is high for one clock, starting in the clock after the last bus cycle ends, and `done_wait` is valid while `done` is high.
- R2: Each bus cycle lasts L = max(`cfg_cyc_len`, 4) clocks. Exactly one of `nand_cle` or `nand_ale` is high for the whole cycle. `nand_we_n` is low from clock floor(L/4) of the cycle for floor(L/2) clocks. `nand_dq` is stable across the rising edge of write enable. A request of N cycles raises `done` N*L clocks after it is accepted.
- R3: Cycles are issued in this fixed order, each one only when it is needed: read-pointer prefix, opcode, column low byte, column high byte, row byte 0, row byte 1, row byte 2, confirm opcode. A request with `req_cmd_en` low sends only its address cycles.
- R4: In small-page mode (`cfg_large_page`=0) a program setup (0x80) is preceded by a read-pointer command chosen from the column. A column of 512 or more gives 0x50 and the column is reduced by 512. A column below 256 gives 0x00 and the column is unchanged. Any other column gives 0x01 and the column is reduced by 256.
- R5: In small-page mode a column takes one address cycle. A row takes two cycles, low byte first, plus a cycle with row bits 23:16 when `cfg_row3` is set.
- R6: In large-page mode a spare-area read (0x50) is sent as 0x00, with 2048 added to the column.
- R7: In large-page mode a column takes two cycles, low byte first. For the 8-bit-address opcodes 0x90, 0xEC, 0xEE and 0xEF only the low column byte is sent.
- R8: When `cfg_bus16` is set the column is halved, except for the 8-bit-address opcodes. In both bus modes `nand_dq[15:8]` is 0x00 on every cycle.
- R9: In large-page mode an opcode 0x00 that carries a column or a row is followed by the confirm opcode 0x30. An opcode 0x00 with neither gets no confirm.
- R10: In large-page mode, opcode 0x05 is followed by the confirm opcode 0xE0. Opcodes 0x05 and 0x85 both report the column-change wait.
- R11: `done_wait` uses these codes: 0 = no wait, 1 = column-change delay, 2 = ready wait. It is 0 for no opcode and for opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF. It is also 0 for opcode 0x00 with no address. Every other request reports 2, unless R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_cmd_en | input | 1 | Request carries an opcode |
| req_opcode | input | 8 | Opcode |
| req_col_en | input | 1 | Request carries a column address |
| req_col | input | COL_W | Column address |
| req_row_en | input | 1 | Request carries a row address |
| req_row | input | ROW_W | Row (page) address |
| cfg_large_page | input | 1 | Large-page sequencing |
| cfg_bus16 | input | 1 | 16-bit data bus |
| cfg_row3 | input | 1 | Third row address byte |
| cfg_cyc_len | input | LEN_W | Clocks per bus cycle (values below 4 act as 4) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_dq | output | 16 | Data bus value |
| nand_dq_oe | output | 1 | Data bus driven |
| done | output | 1 | Request finished (one clock) |
| done_wait | output | 2 | Wait required after the request |

## Verification
The request is accepted on a clock edge. For a request of N bus cycles of L clocks each, `done` is due exactly N*L clocks after that edge. The bench counts falling edges from acceptance until it sees `done`, and compares the count with N*L for cycle lengths of 4, 6 and 8, including a setting below 4 that is clamped to 4.

Each bus cycle is captured at the falling clock edge that first shows write enable high again. The strobes and bus byte in force at that moment are recorded, which is the value the flash latches. The bench also totals the clocks with write enable low and compares the total with N*floor(L/2).

`req_ready` is sampled in the middle of every run. `done_wait` is read in the same half clock in which `done` is seen.

// File: rtl/nand_seq_pkg.sv
// Package: opcodes, wait codes and opcode classes shared by the sequencer.
// Assumes the standard NAND opcode values; slot count is fixed by the cycle order.
package nand_seq_pkg;

    localparam int NSLOT = 8;

    typedef enum logic [1:0] {
        WAIT_NONE  = 2'd0,
        WAIT_TCCS  = 2'd1,
        WAIT_READY = 2'd2
    } wait_e;

    localparam logic [7:0] OP_READ0      = 8'h00;
    localparam logic [7:0] OP_READ1      = 8'h01;
    localparam logic [7:0] OP_RND_OUT    = 8'h05;
    localparam logic [7:0] OP_PROG       = 8'h10;
    localparam logic [7:0] OP_CACHE_PROG = 8'h15;
    localparam logic [7:0] OP_READ_CONF  = 8'h30;
    localparam logic [7:0] OP_READ_SPARE = 8'h50;
    localparam logic [7:0] OP_ERASE_A    = 8'h60;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_PROG_SETUP = 8'h80;
    localparam logic [7:0] OP_RND_IN     = 8'h85;
    localparam logic [7:0] OP_READ_ID    = 8'h90;
    localparam logic [7:0] OP_ERASE_B    = 8'hD0;
    localparam logic [7:0] OP_RND_CONF   = 8'hE0;
    localparam logic [7:0] OP_PARAM_PAGE = 8'hEC;
    localparam logic [7:0] OP_FEAT_GET   = 8'hEE;
    localparam logic [7:0] OP_FEAT_SET   = 8'hEF;

    // Opcodes whose address is a single 8-bit cycle.
    function automatic logic op_is_byte_addr(input logic [7:0] op);
        return (op == OP_READ_ID) || (op == OP_PARAM_PAGE) ||
               (op == OP_FEAT_GET) || (op == OP_FEAT_SET);
    endfunction

    // Opcodes that never need a post-command wait.
    function automatic logic op_needs_no_wait(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_CACHE_PROG) || (op == OP_ERASE_A) ||
               (op == OP_ERASE_B) || (op == OP_PROG_SETUP) || (op == OP_STATUS) ||
               (op == OP_READ_ID) || (op == OP_FEAT_SET);
    endfunction

endpackage

// File: rtl/nand_seq_plan.sv
// Planner: maps one request onto the fixed list of bus-cycle slots.
// Purely combinational; assumes COL_W >= 16 and ROW_W >= 24.
module nand_seq_plan
    import nand_seq_pkg::*;
#(
    parameter int COL_W   = 16,
    parameter int ROW_W   = 24,
    parameter int SP_PAGE = 512,
    parameter int LP_PAGE = 2048
) (
    input  logic                   cmd_en,
    input  logic [7:0]             opcode,
    input  logic                   col_en,
    input  logic [COL_W-1:0]       col,
    input  logic                   row_en,
    input  logic [ROW_W-1:0]       row,
    input  logic                   large_page,
    input  logic                   bus16,
    input  logic                   row3,
    output logic [NSLOT-1:0]       slot_en,
    output logic [NSLOT-1:0]       slot_is_cmd,
    output logic [NSLOT-1:0][7:0]  slot_byte,
    output wait_e                  wait_code
);

    localparam logic [COL_W-1:0] SP_SIZE = COL_W'(SP_PAGE);
    localparam logic [COL_W-1:0] LP_SIZE = COL_W'(LP_PAGE);
    localparam logic [COL_W-1:0] HALF_SP = COL_W'(256);

    logic [7:0]       op_eff;
    logic [7:0]       pre_op;
    logic             pre_en;
    logic [COL_W-1:0] col_eff;
    logic             byte_addr;
    logic             any_addr;
    logic             conf_en;
    logic [7:0]       conf_op;

    // Opcode remap, read-pointer prefix choice and column adjustment.
    always_comb begin
        op_eff  = opcode;
        col_eff = col;
        pre_en  = 1'b0;
        pre_op  = OP_READ0;
        if (large_page && cmd_en && opcode == OP_READ_SPARE) begin
            op_eff  = OP_READ0;
            col_eff = col + LP_SIZE;
        end
        if (!large_page && cmd_en && opcode == OP_PROG_SETUP) begin
            pre_en = 1'b1;
            if (col >= SP_SIZE) begin
                pre_op  = OP_READ_SPARE;
                col_eff = col - SP_SIZE;
            end else if (col < HALF_SP) begin
                pre_op  = OP_READ0;
            end else begin
                pre_op  = OP_READ1;
                col_eff = col - HALF_SP;
            end
        end
        byte_addr = cmd_en && op_is_byte_addr(op_eff);
        if (bus16 && !byte_addr) begin
            col_eff = col_eff >> 1;
        end
    end

    // Confirm opcode selection for large-page reads and random data-out.
    always_comb begin
        any_addr = col_en || row_en;
        conf_en  = 1'b0;
        conf_op  = OP_READ_CONF;
        if (large_page && cmd_en) begin
            if (op_eff == OP_READ0 && any_addr) begin
                conf_en = 1'b1;
                conf_op = OP_READ_CONF;
            end else if (op_eff == OP_RND_OUT) begin
                conf_en = 1'b1;
                conf_op = OP_RND_CONF;
            end
        end
    end

    // Slot table in bus order.
    always_comb begin
        slot_en     = '0;
        slot_is_cmd = '0;
        slot_byte   = '0;
        slot_en[0] = pre_en;                                 slot_is_cmd[0] = 1'b1; slot_byte[0] = pre_op;
        slot_en[1] = cmd_en;                                 slot_is_cmd[1] = 1'b1; slot_byte[1] = op_eff;
        slot_en[2] = col_en;                                 slot_byte[2] = col_eff[7:0];
        slot_en[3] = col_en && large_page && !byte_addr;     slot_byte[3] = col_eff[15:8];
        slot_en[4] = row_en;                                 slot_byte[4] = row[7:0];
        slot_en[5] = row_en;                                 slot_byte[5] = row[15:8];
        slot_en[6] = row_en && row3;                         slot_byte[6] = row[23:16];
        slot_en[7] = conf_en;                                slot_is_cmd[7] = 1'b1; slot_byte[7] = conf_op;
    end

    // Post-command wait classification.
    always_comb begin
        if (!cmd_en || op_needs_no_wait(op_eff)) begin
            wait_code = WAIT_NONE;
        end else if (large_page && (op_eff == OP_RND_IN || op_eff == OP_RND_OUT)) begin
            wait_code = WAIT_TCCS;
        end else if (op_eff == OP_READ0 && !any_addr) begin
            wait_code = WAIT_NONE;
        end else begin
            wait_code = WAIT_READY;
        end
    end

endmodule

// File: rtl/nand_seq_phase.sv
// Phase timer: counts the clocks of one bus cycle and shapes write enable.
// Assumes len >= 4; the low pulse sits in the middle half of the cycle.
module nand_seq_phase #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             we_n,
    output logic             last
);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] lo_start;
    logic [LEN_W-1:0] lo_width;

    assign lo_start = len >> 2;
    assign lo_width = len >> 1;
    assign last     = run && (cnt == len - LEN_W'(1));
    assign we_n     = !(run && (cnt >= lo_start) && (cnt < lo_start + lo_width));

    // Position within the current cycle; restarts at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/nand_cmd_seq.sv
// Top: accepts a request, walks the planned slots as timed bus cycles,
// then pulses done with the wait code. Assumes one chip, no data phase.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_W   = 16,
    parameter int ROW_W   = 24,
    parameter int LEN_W   = 6,
    parameter int SP_PAGE = 512,
    parameter int LP_PAGE = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_cmd_en,
    input  logic [7:0]       req_opcode,
    input  logic             req_col_en,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_row_en,
    input  logic [ROW_W-1:0] req_row,
    input  logic             cfg_large_page,
    input  logic             cfg_bus16,
    input  logic             cfg_row3,
    input  logic [LEN_W-1:0] cfg_cyc_len,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic [15:0]      nand_dq,
    output logic             nand_dq_oe,
    output logic             done,
    output logic [1:0]       done_wait
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(4);

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} state_e;

    state_e               state;
    logic [NSLOT-1:0]     plan_en, plan_cmd;
    logic [NSLOT-1:0][7:0] plan_byte;
    wait_e                plan_wait;
    logic [NSLOT-1:0]     pend;
    logic [NSLOT-1:0]     cmd_q;
    logic [NSLOT-1:0][7:0] byte_q;
    wait_e                wait_q;
    logic [LEN_W-1:0]     len_q;
    logic [NSLOT-1:0]     cur_oh;
    logic                 cur_cmd;
    logic [7:0]           cur_byte;
    logic                 run;
    logic                 cyc_last;
    logic                 accept;

    nand_seq_plan #(
        .COL_W(COL_W), .ROW_W(ROW_W), .SP_PAGE(SP_PAGE), .LP_PAGE(LP_PAGE)
    ) i_plan (
        .cmd_en(req_cmd_en), .opcode(req_opcode),
        .col_en(req_col_en), .col(req_col),
        .row_en(req_row_en), .row(req_row),
        .large_page(cfg_large_page), .bus16(cfg_bus16), .row3(cfg_row3),
        .slot_en(plan_en), .slot_is_cmd(plan_cmd), .slot_byte(plan_byte),
        .wait_code(plan_wait)
    );

    assign run = (state == ST_BUSY);

    nand_seq_phase #(.LEN_W(LEN_W)) i_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .len(len_q),
        .we_n(nand_we_n), .last(cyc_last)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cur_oh    = pend & (~pend + NSLOT'(1));

    // Select the byte and strobe type of the lowest pending slot.
    always_comb begin
        cur_cmd  = 1'b0;
        cur_byte = 8'h00;
        for (int i = 0; i < NSLOT; i++) begin
            if (cur_oh[i]) begin
                cur_cmd  = cmd_q[i];
                cur_byte = byte_q[i];
            end
        end
    end

    // Request capture, slot retirement and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            cmd_q  <= '0;
            byte_q <= '0;
            wait_q <= WAIT_NONE;
            len_q  <= MIN_LEN;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend   <= plan_en;
                        cmd_q  <= plan_cmd;
                        byte_q <= plan_byte;
                        wait_q <= plan_wait;
                        len_q  <= (cfg_cyc_len < MIN_LEN) ? MIN_LEN : cfg_cyc_len;
                        state  <= (plan_en == '0) ? ST_FIN : ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (cyc_last) begin
                        pend <= pend & ~cur_oh;
                        if ((pend & ~cur_oh) == '0) begin
                            state <= ST_FIN;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Bus and completion outputs decoded from state.
    always_comb begin
        nand_ce_n  = !run;
        nand_cle   = run && cur_cmd;
        nand_ale   = run && !cur_cmd;
        nand_dq    = run ? {8'h00, cur_byte} : 16'h0000;
        nand_dq_oe = run;
        done       = (state == ST_FIN);
        done_wait  = (state == ST_FIN) ? wait_q : WAIT_NONE;
    end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Checker: port-level properties of the sequencer, bound to the top module.
module nand_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic [15:0] nand_dq,
    input logic        done,
    input logic [1:0]  done_wait
);

    // R1
    ready_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nand_ce_n);

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (!nand_ce_n && (nand_cle ^ nand_ale)));

    // R2
    dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_dq) && $stable(nand_cle) && !nand_ce_n));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_ce_n |-> (nand_dq[15:8] == 8'h00));

    // R11
    wait_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_wait != 2'd3));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_dq(nand_dq), .done(done), .done_wait(done_wait)
);

// File: tb/test_nand_cmd_seq.sv
// Directed bench: one task per scenario, each comparing captured bus cycles,
// latency, write-enable width and wait code against hand-derived values.
module test_nand_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_cmd_en = 1'b0;
    logic [7:0]  req_opcode = 8'h00;
    logic        req_col_en = 1'b0;
    logic [15:0] req_col = '0;
    logic        req_row_en = 1'b0;
    logic [23:0] req_row = '0;
    logic        cfg_large_page = 1'b0;
    logic        cfg_bus16 = 1'b0;
    logic        cfg_row3 = 1'b0;
    logic [5:0]  cfg_cyc_len = 6'd4;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_dq_oe, done;
    logic [15:0] nand_dq;
    logic [1:0]  done_wait;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [17:0] exp_list [8];
    int          exp_n;
    logic [17:0] got_list [8];
    int          got_n;
    int          we_low;
    logic        prev_we = 1'b1;
    logic        mon_on = 1'b0;

    always #5 clk = ~clk;

    nand_cmd_seq i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd_en(req_cmd_en), .req_opcode(req_opcode),
        .req_col_en(req_col_en), .req_col(req_col),
        .req_row_en(req_row_en), .req_row(req_row),
        .cfg_large_page(cfg_large_page), .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3),
        .cfg_cyc_len(cfg_cyc_len),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_dq(nand_dq), .nand_dq_oe(nand_dq_oe),
        .done(done), .done_wait(done_wait)
    );

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            finish_up();
        end
    end

    // Bus monitor: record strobes and byte at each write-enable rise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (!nand_we_n) we_low <= we_low + 1;
            if (nand_we_n && !prev_we && got_n < 8) begin
                got_list[got_n] <= {nand_cle, nand_ale, nand_dq};
                got_n <= got_n + 1;
            end
        end
        prev_we <= nand_we_n;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] cc(input logic [7:0] b);
        return {2'b10, 8'h00, b};
    endfunction
    function automatic logic [17:0] aa(input logic [7:0] b);
        return {2'b01, 8'h00, b};
    endfunction

    task automatic exp_clear();
        exp_n = 0;
    endtask
    task automatic exp_add(input logic [17:0] v);
        exp_list[exp_n] = v;
        exp_n = exp_n + 1;
    endtask

    // Drive one request, wait for done and check every observable result.
    task automatic run_req(input string tag, input logic lp, input logic b16, input logic r3,
                           input logic ce, input logic [7:0] op,
                           input logic cen, input logic [15:0] col,
                           input logic ren, input logic [23:0] row,
                           input logic [5:0] len, input logic [1:0] exp_wait);
        int lat;
        int l_eff;
        logic ready_mid;
        @(negedge clk);
        got_n = 0;
        we_low = 0;
        mon_on = 1'b1;
        cfg_large_page = lp; cfg_bus16 = b16; cfg_row3 = r3; cfg_cyc_len = len;
        req_cmd_en = ce; req_opcode = op; req_col_en = cen; req_col = col;
        req_row_en = ren; req_row = row; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        ready_mid = req_ready;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat = lat + 1;
        end
        l_eff = (len < 4) ? 4 : int'(len);
        chk(done_wait == exp_wait, {tag, " wait R11"}, done_wait, exp_wait);
        chk(lat == exp_n * l_eff, {tag, " latency R2"}, lat, exp_n * l_eff);
        chk(ready_mid == 1'b0, {tag, " ready while busy R1"}, ready_mid, 0);
        @(negedge clk);
        chk(done == 1'b0 && req_ready && nand_ce_n, {tag, " done pulse R1"},
            {done, req_ready, nand_ce_n}, 3'b011);
        mon_on = 1'b0;
        chk(we_low == exp_n * (l_eff / 2), {tag, " we width R2"}, we_low, exp_n * (l_eff / 2));
        chk(got_n == exp_n, {tag, " cycle count R3"}, got_n, exp_n);
        for (int i = 0; i < 8; i++) begin
            if (i < exp_n && i < got_n)
                chk(got_list[i] == exp_list[i], {tag, " cycle R3"}, got_list[i], exp_list[i]);
        end
    endtask

    task automatic t_reset();
        chk(nand_ce_n && req_ready && !done && !nand_cle && !nand_ale && nand_we_n && !nand_dq_oe,
            "reset state R1", {nand_ce_n, req_ready, done, nand_cle, nand_ale, nand_we_n},
            6'b110001);
    endtask

    task automatic t_sp_prefix_low();   // R4 R5: column below 256
        exp_clear(); exp_add(cc(8'h00)); exp_add(cc(8'h80)); exp_add(aa(8'h10));
        exp_add(aa(8'h34)); exp_add(aa(8'h12));
        run_req("sp prefix low R4", 0, 0, 0, 1, 8'h80, 1, 16'h0010, 1, 24'h001234, 6'd4, 2'd0);
    endtask

    task automatic t_sp_prefix_mid();   // R4: column 256..511
        exp_clear(); exp_add(cc(8'h01)); exp_add(cc(8'h80)); exp_add(aa(8'h50));
        run_req("sp prefix mid R4", 0, 0, 0, 1, 8'h80, 1, 16'h0150, 0, 24'h0, 6'd4, 2'd0);
    endtask

    task automatic t_sp_prefix_spare(); // R4: column at or above 512
        exp_clear(); exp_add(cc(8'h50)); exp_add(cc(8'h80)); exp_add(aa(8'h05));
        run_req("sp prefix spare R4", 0, 0, 0, 1, 8'h80, 1, 16'h0205, 0, 24'h0, 6'd3, 2'd0);
    endtask

    task automatic t_sp_read_row3();    // R5 R11
        exp_clear(); exp_add(cc(8'h00)); exp_add(aa(8'h20)); exp_add(aa(8'h0C));
        exp_add(aa(8'h0B)); exp_add(aa(8'h0A));
        run_req("sp read row3 R5", 0, 0, 1, 1, 8'h00, 1, 16'h0020, 1, 24'h0A0B0C, 6'd6, 2'd2);
    endtask

    task automatic t_lp_spare_read();   // R6 R7 R9
        exp_clear(); exp_add(cc(8'h00)); exp_add(aa(8'h04)); exp_add(aa(8'h08));
        exp_add(aa(8'h02)); exp_add(aa(8'h01)); exp_add(cc(8'h30));
        run_req("lp spare read R6", 1, 0, 0, 1, 8'h50, 1, 16'h0004, 1, 24'h000102, 6'd4, 2'd2);
    endtask

    task automatic t_lp_read_noaddr();  // R9 R11
        exp_clear(); exp_add(cc(8'h00));
        run_req("lp read no addr R9", 1, 0, 0, 1, 8'h00, 0, 16'h0, 0, 24'h0, 6'd8, 2'd0);
    endtask

    task automatic t_lp_rnd_out();      // R10
        exp_clear(); exp_add(cc(8'h05)); exp_add(aa(8'h23)); exp_add(aa(8'h01)); exp_add(cc(8'hE0));
        run_req("lp random out R10", 1, 0, 0, 1, 8'h05, 1, 16'h0123, 0, 24'h0, 6'd4, 2'd1);
    endtask

    task automatic t_lp_rnd_in();       // R10
        exp_clear(); exp_add(cc(8'h85)); exp_add(aa(8'h10)); exp_add(aa(8'h00));
        run_req("lp random in R10", 1, 0, 0, 1, 8'h85, 1, 16'h0010, 0, 24'h0, 6'd4, 2'd1);
    endtask

    task automatic t_lp_bus16_read();   // R8 R9
        exp_clear(); exp_add(cc(8'h00)); exp_add(aa(8'h80)); exp_add(aa(8'h00));
        exp_add(aa(8'h05)); exp_add(aa(8'h00)); exp_add(cc(8'h30));
        run_req("lp bus16 read R8", 1, 1, 0, 1, 8'h00, 1, 16'h0100, 1, 24'h000005, 6'd4, 2'd2);
    endtask

    task automatic t_lp_bus16_readid(); // R7 R8
        exp_clear(); exp_add(cc(8'h90)); exp_add(aa(8'h20));
        run_req("lp bus16 read id R7", 1, 1, 0, 1, 8'h90, 1, 16'h0020, 0, 24'h0, 6'd4, 2'd0);
    endtask

    task automatic t_addr_only();       // R3 R11
        exp_clear(); exp_add(aa(8'h07)); exp_add(aa(8'h00));
        run_req("address only R3", 1, 0, 0, 0, 8'h00, 1, 16'h0007, 0, 24'h0, 6'd4, 2'd0);
    endtask

    task automatic t_sp_erase();        // R5 R11
        exp_clear(); exp_add(cc(8'h60)); exp_add(aa(8'h56)); exp_add(aa(8'h34));
        run_req("sp erase R11", 0, 0, 0, 1, 8'h60, 0, 16'h0, 1, 24'h003456, 6'd4, 2'd0);
    endtask

    task automatic t_lp_reset();        // R11
        exp_clear(); exp_add(cc(8'hFF));
        run_req("lp reset R11", 1, 0, 0, 1, 8'hFF, 0, 16'h0, 0, 24'h0, 6'd4, 2'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sp_prefix_low();
        t_sp_prefix_mid();
        t_sp_prefix_spare();
        t_sp_read_row3();
        t_lp_spare_read();
        t_lp_read_noaddr();
        t_lp_rnd_out();
        t_lp_rnd_in();
        t_lp_bus16_read();
        t_lp_bus16_readid();
        t_addr_only();
        t_sp_erase();
        t_lp_reset();
        finish_up();
    end

endmodule